// File: doc/BRIEF.md
# Unaligned Word Load/Store Byte Merger

This block performs the byte-lane merging behind the four partial-word instructions of a little-endian 32-bit core: load-left, load-right, store-left and store-right. A pair of these instructions moves a word that straddles an alignment boundary. Each instruction reads the aligned memory word that contains the effective address and combines some of its bytes with bytes of a register. The low address bits select the bytes, and the left and right variants use different, asymmetric selections.

For a load, the register side is the current register value. If the load-delay slot still holds an unwritten result for the same destination register, that pending value is used instead. The merged value leaves through the load-delay slot outputs. For a store, the block reads the aligned word, merges the register bytes into it and writes it back to the same aligned address. One operation is in flight at a time. The operation starts on a `start` pulse and ends with a one-cycle `done` pulse.

Top module: `unaligned_merge`

## Requirements
- R1: Every memory access uses the effective address with bits 1:0 cleared. Any alignment is accepted and no address-error signal exists.
- R2: Op code 2'b00 (load-left), with off = eff_addr[1:0] and the register value as base: result byte j takes memory byte j-(3-off) when j >= 3-off, and otherwise keeps register byte j.
- R3: Op code 2'b01 (load-right): result byte j takes memory byte j+off when j <= 3-off, and otherwise keeps register byte j.
- R4: Op code 2'b10 (store-left): written byte j takes register byte j+3-off when j <= off, and otherwise keeps memory byte j.
- R5: Op code 2'b11 (store-right): written byte j takes register byte j-off when j >= off, and otherwise keeps memory byte j.
- R6: For loads only, the base is pend_data when pend_valid is 1 and pend_reg equals dst_reg at the start cycle. Otherwise the base is reg_value. Stores always use reg_value.
- R7: For a load, ld_valid, ld_reg (= dst_reg) and ld_data rise for one cycle together with done. This happens in the cycle after the clock edge that accepts read data, and no memory write occurs.
- R8: For a store, the read completes first. In the cycle after the edge that accepts read data, mem_req and mem_we are both 1 for exactly one cycle with the merged word. done pulses in the next cycle.
- R9: A start while an operation is in progress is ignored. The address on the bus and the result stay those of the running operation.
- R10: During and right after reset, mem_req, done and ld_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| eff_addr | input | 32 | Effective byte address |
| dst_reg | input | 5 | Register index of the operation |
| reg_value | input | 32 | Register file value of dst_reg |
| pend_valid | input | 1 | Load-delay slot holds a pending result |
| pend_reg | input | 5 | Destination of the pending result |
| pend_data | input | 32 | Data of the pending result |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged store word |
| mem_rdata | input | 32 | Aligned read word |
| mem_rvalid | input | 1 | Read data valid |
| ld_valid | output | 1 | Load-delay slot write strobe |
| ld_reg | output | 5 | Load-delay slot destination |
| ld_data | output | 32 | Merged load result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a load-left or load-right whose destination matches a pending delayed load, because the forwarded value must win only for loads and only when valid. The stimulus sweeps every op and offset with three variants: a matching pending load, a pending load to another register, and a matching register index with pend_valid low. Stores get the same variants so that they can be shown to ignore the slot. Read latency varies from zero to several cycles. A start is injected while a read is outstanding to show that it is ignored.

// File: rtl/ua_merge_pkg.sv
package ua_merge_pkg;

  typedef enum logic [1:0] {
    UA_LD_LEFT  = 2'b00,
    UA_LD_RIGHT = 2'b01,
    UA_ST_LEFT  = 2'b10,
    UA_ST_RIGHT = 2'b11
  } ua_op_e;

  typedef enum logic [1:0] {
    UA_IDLE  = 2'b00,
    UA_READ  = 2'b01,
    UA_WRITE = 2'b10
  } ua_state_e;

  function automatic logic ua_is_store(ua_op_e op);
    return op[1];
  endfunction

  // bit distance for the left-flavoured shift
  function automatic int ua_left_bits(int off, int lanes);
    return 8 * (lanes - 1 - off);
  endfunction

  // bit distance for the right-flavoured shift
  function automatic int ua_right_bits(int off);
    return 8 * off;
  endfunction

  // 1 when lane takes its byte from the shifted (moving) operand
  function automatic logic ua_lane_from_mover(ua_op_e op, int lane, int off, int lanes);
    case (op)
      UA_LD_LEFT:  return lane >= (lanes - 1 - off);
      UA_LD_RIGHT: return lane <= (lanes - 1 - off);
      UA_ST_LEFT:  return lane <= off;
      default:     return lane >= off;
    endcase
  endfunction

endpackage

// File: rtl/ua_fwd_sel.sv
module ua_fwd_sel #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              is_load,
  input  logic [REG_AW-1:0] dst_reg,
  input  logic [DATA_W-1:0] reg_value,
  input  logic              pend_valid,
  input  logic [REG_AW-1:0] pend_reg,
  input  logic [DATA_W-1:0] pend_data,
  output logic [DATA_W-1:0] base_value,
  output logic              fwd_hit
);
  assign fwd_hit    = is_load && pend_valid && (pend_reg == dst_reg);
  assign base_value = fwd_hit ? pend_data : reg_value;
endmodule

// File: rtl/ua_lane_merge.sv
module ua_lane_merge
  import ua_merge_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  ua_op_e            op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] reg_word,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keeper;
  logic [LANES-1:0]  take;

  always_comb begin
    case (op)
      UA_LD_LEFT:  shifted = mem_word << ua_left_bits(int'(off), LANES);
      UA_LD_RIGHT: shifted = mem_word >> ua_right_bits(int'(off));
      UA_ST_LEFT:  shifted = reg_word >> ua_left_bits(int'(off), LANES);
      default:     shifted = reg_word << ua_right_bits(int'(off));
    endcase
    keeper = ua_is_store(op) ? mem_word : reg_word;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign take[j] = ua_lane_from_mover(op, j, int'(off), LANES);
    assign merged[8*j +: 8] = take[j] ? shifted[8*j +: 8] : keeper[8*j +: 8];
  end
endmodule

// File: rtl/ua_seq.sv
module ua_seq
  import ua_merge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_store,
  input  logic mem_rvalid,
  output logic accept,
  output logic rd_ack,
  output logic wr_fire,
  output logic busy_rd,
  output logic done
);
  ua_state_e state_q, state_d;

  assign busy_rd = (state_q == UA_READ);
  assign wr_fire = (state_q == UA_WRITE);
  assign accept  = (state_q == UA_IDLE) && start;
  assign rd_ack  = busy_rd && mem_rvalid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      UA_IDLE:  if (start) state_d = UA_READ;
      UA_READ:  if (mem_rvalid) state_d = is_store ? UA_WRITE : UA_IDLE;
      default:  state_d = UA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UA_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (rd_ack && !is_store) || wr_fire;
    end
  end
endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
  import ua_merge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [REG_AW-1:0] dst_reg,
  input  logic [DATA_W-1:0] reg_value,
  input  logic              pend_valid,
  input  logic [REG_AW-1:0] pend_reg,
  input  logic [DATA_W-1:0] pend_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              ld_valid,
  output logic [REG_AW-1:0] ld_reg,
  output logic [DATA_W-1:0] ld_data,
  output logic              done
);
  ua_op_e            op_in, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_AW-1:0] dst_q;
  logic [DATA_W-1:0] base_q, base_in, merged, wdata_q;
  logic              fwd_hit, accept, rd_ack, wr_fire, busy_rd;

  assign op_in = ua_op_e'(op);

  ua_fwd_sel #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_fwd (
    .is_load    (!ua_is_store(op_in)),
    .dst_reg    (dst_reg),
    .reg_value  (reg_value),
    .pend_valid (pend_valid),
    .pend_reg   (pend_reg),
    .pend_data  (pend_data),
    .base_value (base_in),
    .fwd_hit    (fwd_hit)
  );

  ua_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .is_store   (ua_is_store(op_q)),
    .mem_rvalid (mem_rvalid),
    .accept     (accept),
    .rd_ack     (rd_ack),
    .wr_fire    (wr_fire),
    .busy_rd    (busy_rd),
    .done       (done)
  );

  ua_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .op       (op_q),
    .off      (addr_q[OFF_W-1:0]),
    .reg_word (base_q),
    .mem_word (mem_rdata),
    .merged   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= UA_LD_LEFT;
      addr_q   <= '0;
      dst_q    <= '0;
      base_q   <= '0;
      wdata_q  <= '0;
      ld_valid <= 1'b0;
      ld_reg   <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= 1'b0;
      if (accept) begin
        op_q   <= op_in;
        addr_q <= eff_addr;
        dst_q  <= dst_reg;
        base_q <= base_in;
      end
      if (rd_ack) begin
        if (ua_is_store(op_q)) begin
          wdata_q <= merged;
        end else begin
          ld_valid <= 1'b1;
          ld_reg   <= dst_q;
          ld_data  <= merged;
        end
      end
    end
  end

  assign mem_req   = busy_rd || wr_fire;
  assign mem_we    = wr_fire;
  assign mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/ua_merge_checker.sv
module ua_merge_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              rd_ack,
  input logic              done,
  input logic              ld_valid
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R1

  AST_WRITE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(rd_ack)); // R8

  AST_STORE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (done && !mem_we)); // R8

  AST_LOAD_SLOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (done && !mem_req)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R9
endmodule

bind unaligned_merge ua_merge_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .rd_ack     (rd_ack),
  .done       (done),
  .ld_valid   (ld_valid)
);

// File: tb/unaligned_merge_bench.sv
`timescale 1ns/1ps
module unaligned_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] eff_addr = '0;
  logic [4:0]  dst_reg = '0;
  logic [31:0] reg_value = '0;
  logic        pend_valid = 1'b0;
  logic [4:0]  pend_reg = '0;
  logic [31:0] pend_data = '0;
  logic        mem_req, mem_we, ld_valid, done;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [4:0]  ld_reg;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int lat_target = 0;
  int lat_cnt = 0;

  always #2 clk = ~clk;

  unaligned_merge u_unaligned_merge (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .eff_addr(eff_addr),
    .dst_reg(dst_reg), .reg_value(reg_value), .pend_valid(pend_valid),
    .pend_reg(pend_reg), .pend_data(pend_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .ld_valid(ld_valid),
    .ld_reg(ld_reg), .ld_data(ld_data), .done(done)
  );

  // byte-by-byte restatement of the four merge rules (R2..R5)
  function automatic [31:0] ref_merge(int kind, int off, logic [31:0] r, logic [31:0] m);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      case (kind)
        0: res[8*b +: 8] = (b >= 3 - off) ? m[8*(b-(3-off)) +: 8] : r[8*b +: 8];
        1: res[8*b +: 8] = (b <= 3 - off) ? m[8*(b+off) +: 8] : r[8*b +: 8];
        2: res[8*b +: 8] = (b <= off) ? r[8*(b+3-off) +: 8] : m[8*b +: 8];
        default: res[8*b +: 8] = (b >= off) ? r[8*(b-off) +: 8] : m[8*b +: 8];
      endcase
    end
    return res;
  endfunction

  // reference model state
  int          m_phase = 0;
  int          m_kind = 0;
  logic [31:0] m_addr = '0, m_base = '0, m_wdata = '0, m_lddata = '0;
  logic [4:0]  m_dst = '0, m_ldreg = '0;
  logic        m_fwd = 1'b0, m_done = 1'b0, m_ldv = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_ldv = 0;
    end else begin
      m_done = 0; m_ldv = 0;
      if (m_phase == 0) begin
        if (start) begin
          m_kind = int'(op);
          m_addr = eff_addr;
          m_dst  = dst_reg;
          m_fwd  = (op < 2) && pend_valid && (pend_reg == dst_reg);
          m_base = m_fwd ? pend_data : reg_value;
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (mem_rvalid) begin
          if (m_kind < 2) begin
            m_ldv = 1; m_done = 1; m_ldreg = m_dst;
            m_lddata = ref_merge(m_kind, int'(m_addr[1:0]), m_base, mem_rdata);
            m_phase = 0;
          end else begin
            m_wdata = ref_merge(m_kind, int'(m_addr[1:0]), m_base, mem_rdata);
            m_phase = 2;
          end
        end
      end else begin
        m_done = 1; m_phase = 0;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic string data_tag(int kind, logic fwd);
    if (fwd) return "R6";
    case (kind)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // cycle-by-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(mem_req === (m_phase != 0), "R1", 32'(mem_req), 32'(m_phase != 0));
      if (m_phase != 0) begin
        check(mem_addr === {m_addr[31:2], 2'b00}, "R1", mem_addr, {m_addr[31:2], 2'b00});
        check(mem_we === (m_phase == 2), "R8", 32'(mem_we), 32'(m_phase == 2));
      end
      if (m_phase == 2)
        check(mem_wdata === m_wdata, data_tag(m_kind, 1'b0), mem_wdata, m_wdata);
      check(done === m_done, (m_kind < 2) ? "R7" : "R8", 32'(done), 32'(m_done));
      check(ld_valid === m_ldv, "R7", 32'(ld_valid), 32'(m_ldv));
      if (m_ldv) begin
        check(ld_reg === m_ldreg, "R7", 32'(ld_reg), 32'(m_ldreg));
        check(ld_data === m_lddata, data_tag(m_kind, m_fwd), ld_data, m_lddata);
      end
    end
  end

  // memory responder with programmable read latency
  always @(posedge clk) begin
    #1;
    if (mem_req && !mem_we && !mem_rvalid) begin
      if (lat_cnt >= lat_target) begin
        mem_rvalid = 1'b1;
        mem_rdata  = {mem_addr[15:0] ^ 16'hC35A, ~mem_addr[31:16]} ^ 32'h1E0F_7788;
        lat_cnt = 0;
      end else begin
        lat_cnt++;
      end
    end else begin
      mem_rvalid = 1'b0;
      lat_cnt = 0;
    end
  end

  task automatic run_op(input int kind, input logic [31:0] a, input logic [4:0] d,
                        input logic [31:0] rv, input logic pv, input logic [4:0] pr,
                        input logic [31:0] pd, input int lat, input logic intrude);
    @(posedge clk); #1;
    lat_target = lat;
    op = 2'(kind); eff_addr = a; dst_reg = d; reg_value = rv;
    pend_valid = pv; pend_reg = pr; pend_data = pd;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (intrude) begin
      // R9: a second start while the read is outstanding
      op = 2'(3 - kind); eff_addr = ~a; reg_value = ~rv; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      check(mem_addr === {a[31:2], 2'b00}, "R9", mem_addr, {a[31:2], 2'b00});
      @(posedge clk); #1;
    end
    while (m_phase != 0) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired (R7 R8 completion)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_req === 1'b0, "R10", 32'(mem_req), 0);
    check(done === 1'b0, "R10", 32'(done), 0);
    check(ld_valid === 1'b0, "R10", 32'(ld_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req === 1'b0, "R10", 32'(mem_req), 0);
    check(done === 1'b0, "R10", 32'(done), 0);

    // every op and offset, three forwarding variants, varying latency
    for (int k = 0; k < 4; k++) begin
      for (int o = 0; o < 4; o++) begin
        for (int v = 0; v < 3; v++) begin
          logic [31:0] a = 32'h4000_1230 + 32'(o) + 32'(v << 8) + 32'(k << 12);
          run_op(k, a, 5'd9, 32'hA1B2_C3D4 ^ 32'(o * 3 + v), v != 2, (v == 1) ? 5'd10 : 5'd9,
                 32'h0F1E_2D3C + 32'(k), (o + v) % 4, 1'b0);
        end
      end
    end

    // ignored start while busy
    run_op(0, 32'h0000_0102, 5'd3, 32'h1122_3344, 1'b0, 5'd0, '0, 3, 1'b1);
    run_op(3, 32'h0000_0207, 5'd4, 32'h5566_7788, 1'b1, 5'd4, 32'hDEAD_BEEF, 2, 1'b1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [4:0] d = 5'($urandom_range(0, 31));
      run_op(int'($urandom_range(0, 3)), $urandom, d, $urandom, 1'($urandom_range(0, 1)),
             ($urandom_range(0, 1) != 0) ? d : 5'($urandom_range(0, 31)), $urandom,
             int'($urandom_range(0, 4)), 1'($urandom_range(0, 7) == 0));
    end

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule